// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block is the hardware loop behind a vector instruction. Once started, it walks an element index from a resume point up to the vector length. For every element it presents a source register number and a destination register number to a downstream issue port, one operation per clock, under a valid/ready handshake. An operand marked as vector moves to a new register number on every issued step. An operand marked as scalar stays on its base register, apart from its sub-element offset. When the sub-vector length is greater than one, each element becomes a group of consecutive sub-steps, and that group is enabled or skipped as a whole.

Two optional masks gate execution, one for the source side and one for the destination side. A 3-bit code selects which masks are in use and whether they are inverted. The source and destination indices skip their disabled elements independently, so a compress or expand pattern comes out of the index pairing. If a predicate is applied to a scalar operand, the loop ends after the first enabled element, which gives splat and select behaviour. When a run finishes normally, the resume index returns to zero. When the issue side reports a trap, the resume index records the failing element so that a later run can pick up from there.

All operation inputs are latched on the start strobe. Changing them during a run has no effect.

Top module: `pvs_seq_top`

## Requirements
- R1: After reset the block is idle: `issue_valid` and `done` are low and `vstart_out` is 0.
- R2: For a vector operand, the presented register is base + element_index * len + sub (modulo 2^REG_W). Across accepted steps, element indices rise strictly from the start index.
- R3: For a scalar operand, the presented register is base + sub on every step, whatever the element index.
- R4: `svlen_code` 00, 01, 10 and 11 select len 1, 2, 3 and 4. Each enabled element issues len sub-steps with `issue_sub` running 0 to len-1, and a predicate bit enables or skips the whole group.
- R5: The loop starts at `vstart_in`. If `vstart_in` >= `vl`, nothing is issued and the run completes at once.
- R6: `tpred[1:0]` selects the masks: 00 none, 01 source mask, 10 destination mask, 11 both. Mask bit i enables element i. Source and destination indices skip their disabled elements independently, and the run ends when either side has no enabled element left below `vl`.
- R7: `tpred[2]`=1 inverts whichever masks are in use. Code 100 is unpredicated, and both masks are ignored.
- R8: If a scalar operand has its own side's mask in use, the run ends after the group of the first pair in which that side is enabled.
- R9: With `vl`=0, nothing is issued and `done` is high in the cycle directly after the start edge.
- R10: Normal completion gives a single-cycle `done` pulse and sets `vstart_out` to 0.
- R11: A `trap` during a run stops issuing. `done` pulses in the next cycle and `vstart_out` becomes the destination element index of the step that was being presented.
- R12: With `issue_ready` held high, one step is accepted per cycle. While `issue_valid` is high and `issue_ready` is low, the presented step stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe; honoured only when idle |
| vl | input | IDX_W | Vector length (number of elements) |
| vstart_in | input | IDX_W | First element index of the run |
| svlen_code | input | 2 | Sub-vector length code |
| src_vec | input | 1 | Source operand is a vector (1) or a scalar (0) |
| dst_vec | input | 1 | Destination operand is a vector (1) or a scalar (0) |
| src_base | input | REG_W | Source base register number |
| dst_base | input | REG_W | Destination base register number |
| src_mask | input | MAX_VL | Source predicate mask |
| dst_mask | input | MAX_VL | Destination predicate mask |
| tpred | input | 3 | Twin-predicate selection code |
| trap | input | 1 | Abort the run at the presented step |
| issue_valid | output | 1 | A step is presented |
| issue_ready | input | 1 | Downstream accepts the presented step |
| issue_src_reg | output | REG_W | Source register number of the step |
| issue_dst_reg | output | REG_W | Destination register number of the step |
| issue_src_idx | output | IDX_W | Source element index of the step |
| issue_dst_idx | output | IDX_W | Destination element index of the step |
| issue_sub | output | 2 | Sub-element index within the group |
| done | output | 1 | One-cycle pulse at the end of a run |
| vstart_out | output | IDX_W | Resume index: 0 after completion, failing element after a trap |

## Verification
The hardest state to reach from the ports is a trap that arrives on one exact element while the loop is running. The bench watches the presented destination index at the falling edge. When it sees the step just before the target element, it raises `trap` right after the next rising edge, so the target element is the one being presented when the trap is taken. It then checks the resume index and confirms that no later step was accepted. Sub-steps stalled by backpressure and a scalar predicated destination stopping at a mask bit deep in the vector are reached with a fixed ready pattern and masks whose first enabled bits sit at different positions on the two sides.

// File: rtl/pvs_pkg.sv
package pvs_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_t;

   typedef struct packed {
      logic use_src;
      logic use_dst;
      logic invert;
   } pred_sel_t;

   // Sub-vector code to group length 1..4.
   function automatic logic [2:0] group_len(input logic [1:0] code);
      return {1'b0, code} + 3'd1;
   endfunction

   // Low two bits pick the masks, the top bit inverts them; an empty
   // selection ignores the invert bit (covers the reserved code).
   function automatic pred_sel_t decode_pred(input logic [2:0] code);
      pred_sel_t s;
      s.use_src = code[0];
      s.use_dst = code[1];
      s.invert  = code[2] & (code[1:0] != 2'b00);
      return s;
   endfunction

endpackage

// File: rtl/pvs_scan.sv
// Finds the lowest set mask bit at or above `from` and below `limit`.
module pvs_scan #(
   parameter int N  = 64,
   parameter int IW = 7
) (
   input  logic [N-1:0]  mask,
   input  logic [IW-1:0] from,
   input  logic [IW-1:0] limit,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i] && (i >= int'(from)) && (i < int'(limit))) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/pvs_regcalc.sv
// Register number of one operand for the presented step.
module pvs_regcalc #(
   parameter int RW = 7,
   parameter int IW = 7
) (
   input  logic [RW-1:0] base,
   input  logic          is_vec,
   input  logic [IW-1:0] elem,
   input  logic [1:0]    sub,
   input  logic [2:0]    len,
   output logic [RW-1:0] reg_num
);
   int unsigned offset;

   always_comb begin
      if (is_vec)
         offset = int'(elem) * int'(len) + int'(sub);
      else
         offset = int'(sub);
      reg_num = base + RW'(offset);
   end
endmodule

// File: rtl/pvs_seq_top.sv
module pvs_seq_top #(
   parameter int MAX_VL    = 64,
   parameter int REG_W     = 7,
   parameter int IDX_W     = $clog2(MAX_VL + 1),
   parameter bit SUBVEC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  vl,
   input  logic [IDX_W-1:0]  vstart_in,
   input  logic [1:0]        svlen_code,
   input  logic              src_vec,
   input  logic              dst_vec,
   input  logic [REG_W-1:0]  src_base,
   input  logic [REG_W-1:0]  dst_base,
   input  logic [MAX_VL-1:0] src_mask,
   input  logic [MAX_VL-1:0] dst_mask,
   input  logic [2:0]        tpred,
   input  logic              trap,
   output logic              issue_valid,
   input  logic              issue_ready,
   output logic [REG_W-1:0]  issue_src_reg,
   output logic [REG_W-1:0]  issue_dst_reg,
   output logic [IDX_W-1:0]  issue_src_idx,
   output logic [IDX_W-1:0]  issue_dst_idx,
   output logic [1:0]        issue_sub,
   output logic              done,
   output logic [IDX_W-1:0]  vstart_out
);
   import pvs_pkg::*;

   localparam int SIDES = 2;   // 0: source, 1: destination

   // ---------------- elaboration checks ----------------
   if (MAX_VL < 1) begin : g_chk_vl
      $error("pvs_seq_top: MAX_VL must be at least 1");
   end
   if (IDX_W < $clog2(MAX_VL + 1)) begin : g_chk_idx
      $error("pvs_seq_top: IDX_W too narrow to hold MAX_VL");
   end
   if (REG_W < 3) begin : g_chk_reg
      $error("pvs_seq_top: REG_W must be at least 3");
   end

   // ---------------- start-time decode ----------------
   logic [2:0] len_in;
   if (SUBVEC_EN) begin : g_subvec
      assign len_in = group_len(svlen_code);
   end else begin : g_nosubvec
      logic sv_code_unused;
      assign sv_code_unused = ^svlen_code;
      assign len_in = 3'd1;
   end

   pred_sel_t psel;
   assign psel = decode_pred(tpred);

   logic [MAX_VL-1:0] smask_in, dmask_in;
   always_comb begin
      smask_in = psel.use_src ? (src_mask ^ {MAX_VL{psel.invert}}) : '1;
      dmask_in = psel.use_dst ? (dst_mask ^ {MAX_VL{psel.invert}}) : '1;
   end

   // ---------------- run state ----------------
   seq_state_t        st_q;
   logic [IDX_W-1:0]  vl_q;
   logic [2:0]        len_q;
   logic              svec_q, dvec_q;
   logic [REG_W-1:0]  sbase_q, dbase_q;
   logic [MAX_VL-1:0] smask_q, dmask_q;
   logic              early_stop_q;
   logic [IDX_W-1:0]  si_q, di_q;
   logic [1:0]        sub_q;
   logic              done_q;
   logic [IDX_W-1:0]  vstart_q;
   logic              running;

   assign running = (st_q == SEQ_RUN);

   // ---------------- per-side scan and register number ----------------
   logic [MAX_VL-1:0] side_mask  [SIDES];
   logic [IDX_W-1:0]  side_from  [SIDES];
   logic              side_vec   [SIDES];
   logic [REG_W-1:0]  side_base  [SIDES];
   logic              side_found [SIDES];
   logic [IDX_W-1:0]  side_idx   [SIDES];
   logic [REG_W-1:0]  side_reg   [SIDES];

   assign side_mask[0] = smask_q;
   assign side_mask[1] = dmask_q;
   assign side_from[0] = si_q;
   assign side_from[1] = di_q;
   assign side_vec[0]  = svec_q;
   assign side_vec[1]  = dvec_q;
   assign side_base[0] = sbase_q;
   assign side_base[1] = dbase_q;

   for (genvar g = 0; g < SIDES; g++) begin : g_side
      pvs_scan #(.N(MAX_VL), .IW(IDX_W)) u_scan (
         .mask  (side_mask[g]),
         .from  (side_from[g]),
         .limit (vl_q),
         .found (side_found[g]),
         .idx   (side_idx[g])
      );
      pvs_regcalc #(.RW(REG_W), .IW(IDX_W)) u_reg (
         .base    (side_base[g]),
         .is_vec  (side_vec[g]),
         .elem    (side_idx[g]),
         .sub     (sub_q),
         .len     (len_q),
         .reg_num (side_reg[g])
      );
   end

   logic pair_ok, last_sub;
   assign pair_ok  = side_found[0] & side_found[1];
   assign last_sub = (({1'b0, sub_q}) + 3'd1) == len_q;

   assign issue_valid   = running & pair_ok;
   assign issue_src_reg = side_reg[0];
   assign issue_dst_reg = side_reg[1];
   assign issue_src_idx = side_idx[0];
   assign issue_dst_idx = side_idx[1];
   assign issue_sub     = sub_q;
   assign done          = done_q;
   assign vstart_out    = vstart_q;

   // ---------------- sequencing ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= SEQ_IDLE;
         vl_q         <= '0;
         len_q        <= 3'd1;
         svec_q       <= 1'b0;
         dvec_q       <= 1'b0;
         sbase_q      <= '0;
         dbase_q      <= '0;
         smask_q      <= '0;
         dmask_q      <= '0;
         early_stop_q <= 1'b0;
         si_q         <= '0;
         di_q         <= '0;
         sub_q        <= '0;
         done_q       <= 1'b0;
         vstart_q     <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            SEQ_IDLE: begin
               if (start) begin
                  vl_q         <= vl;
                  len_q        <= len_in;
                  svec_q       <= src_vec;
                  dvec_q       <= dst_vec;
                  sbase_q      <= src_base;
                  dbase_q      <= dst_base;
                  smask_q      <= smask_in;
                  dmask_q      <= dmask_in;
                  early_stop_q <= (!src_vec && psel.use_src) ||
                                  (!dst_vec && psel.use_dst);
                  si_q         <= vstart_in;
                  di_q         <= vstart_in;
                  sub_q        <= '0;
                  if ((vl == '0) || (vstart_in >= vl)) begin
                     done_q   <= 1'b1;
                     vstart_q <= '0;
                  end else begin
                     st_q <= SEQ_RUN;
                  end
               end
            end
            SEQ_RUN: begin
               if (trap) begin
                  st_q     <= SEQ_IDLE;
                  done_q   <= 1'b1;
                  vstart_q <= side_found[1] ? side_idx[1] : di_q;
               end else if (!pair_ok) begin
                  st_q     <= SEQ_IDLE;
                  done_q   <= 1'b1;
                  vstart_q <= '0;
               end else if (issue_ready) begin
                  if (last_sub) begin
                     sub_q <= '0;
                     if (early_stop_q) begin
                        st_q     <= SEQ_IDLE;
                        done_q   <= 1'b1;
                        vstart_q <= '0;
                     end else begin
                        si_q <= side_idx[0] + IDX_W'(1);
                        di_q <= side_idx[1] + IDX_W'(1);
                     end
                  end else begin
                     sub_q <= sub_q + 2'd1;
                  end
               end
            end
            default: st_q <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pvs_seq_chk.sv
module pvs_seq_chk #(
   parameter int MAX_VL    = 64,
   parameter int REG_W     = 7,
   parameter int IDX_W     = 7,
   parameter bit SUBVEC_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             running,
   input logic [IDX_W-1:0] vl,
   input logic [1:0]       svlen_code,
   input logic             src_vec,
   input logic [REG_W-1:0] src_base,
   input logic             trap,
   input logic             issue_valid,
   input logic             issue_ready,
   input logic [REG_W-1:0] issue_src_reg,
   input logic [IDX_W-1:0] issue_dst_idx,
   input logic [1:0]       issue_sub,
   input logic             done
);
   logic [IDX_W-1:0] cap_vl;
   logic [2:0]       cap_len;
   logic             cap_svec;
   logic [REG_W-1:0] cap_sbase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_vl    <= '0;
         cap_len   <= 3'd1;
         cap_svec  <= 1'b0;
         cap_sbase <= '0;
      end else if (start && !running) begin
         cap_vl    <= vl;
         cap_len   <= SUBVEC_EN ? ({1'b0, svlen_code} + 3'd1) : 3'd1;
         cap_svec  <= src_vec;
         cap_sbase <= src_base;
      end
   end

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_ready && !trap) |=>
         (issue_valid && $stable(issue_src_reg) && $stable(issue_dst_idx) &&
          $stable(issue_sub)));

   assert_scalar_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !cap_svec) |-> (issue_src_reg == cap_sbase + REG_W'(issue_sub)));

   assert_step_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> ((issue_dst_idx < cap_vl) && (({1'b0, issue_sub}) < cap_len)));

   assert_trap_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (running && trap) |=> (done && !issue_valid));

   assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !issue_valid);

endmodule

bind pvs_seq_top pvs_seq_chk #(
   .MAX_VL(MAX_VL), .REG_W(REG_W), .IDX_W(IDX_W), .SUBVEC_EN(SUBVEC_EN)
) u_pvs_seq_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .running       (running),
   .vl            (vl),
   .svlen_code    (svlen_code),
   .src_vec       (src_vec),
   .src_base      (src_base),
   .trap          (trap),
   .issue_valid   (issue_valid),
   .issue_ready   (issue_ready),
   .issue_src_reg (issue_src_reg),
   .issue_dst_idx (issue_dst_idx),
   .issue_sub     (issue_sub),
   .done          (done)
);

// File: tb/pvs_seq_top_bench.sv
module pvs_seq_top_bench;
   localparam int N  = 64;
   localparam int RW = 7;
   localparam int IW = 7;
   localparam int MAXE = 256;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, start, src_vec, dst_vec, trap, issue_ready;
   logic [IW-1:0] vl, vstart_in;
   logic [1:0]    svlen_code;
   logic [RW-1:0] src_base, dst_base;
   logic [N-1:0]  src_mask, dst_mask;
   logic [2:0]    tpred;
   logic          issue_valid, done;
   logic [RW-1:0] issue_src_reg, issue_dst_reg;
   logic [IW-1:0] issue_src_idx, issue_dst_idx, vstart_out;
   logic [1:0]    issue_sub;

   pvs_seq_top #(.MAX_VL(N), .REG_W(RW), .IDX_W(IW)) u_pvs_seq_top (
      .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .vstart_in(vstart_in),
      .svlen_code(svlen_code), .src_vec(src_vec), .dst_vec(dst_vec),
      .src_base(src_base), .dst_base(dst_base), .src_mask(src_mask),
      .dst_mask(dst_mask), .tpred(tpred), .trap(trap),
      .issue_valid(issue_valid), .issue_ready(issue_ready),
      .issue_src_reg(issue_src_reg), .issue_dst_reg(issue_dst_reg),
      .issue_src_idx(issue_src_idx), .issue_dst_idx(issue_dst_idx),
      .issue_sub(issue_sub), .done(done), .vstart_out(vstart_out)
   );

   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // backpressure pattern
   bit       bp_mode = 1'b0;
   bit [4:0] bp_pat = 5'b10110;
   always @(posedge clk) begin
      #2;
      issue_ready = bp_mode ? bp_pat[cyc % 5] : 1'b1;
   end

   // captured accepted steps
   int got_sr[MAXE], got_dr[MAXE], got_si[MAXE], got_di[MAXE], got_sub[MAXE], got_cyc[MAXE];
   int got_n = 0, done_cnt = 0, done_cyc = 0;
   int exp_sr[MAXE], exp_dr[MAXE], exp_si[MAXE], exp_di[MAXE], exp_sub[MAXE];
   int exp_n = 0;

   bit            hold_pend = 1'b0;
   logic [RW-1:0] h_sr, h_dr;
   logic [IW-1:0] h_di;
   logic [1:0]    h_sub;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pend)
            chk(issue_valid && issue_src_reg == h_sr && issue_dst_reg == h_dr &&
                issue_dst_idx == h_di && issue_sub == h_sub,
                "R12", "stalled step held", int'(issue_dst_reg), int'(h_dr));
         hold_pend = issue_valid && !issue_ready && !trap;
         h_sr = issue_src_reg; h_dr = issue_dst_reg; h_di = issue_dst_idx; h_sub = issue_sub;
         if (issue_valid && issue_ready && !trap && got_n < MAXE) begin
            got_sr[got_n]  = int'(issue_src_reg);
            got_dr[got_n]  = int'(issue_dst_reg);
            got_si[got_n]  = int'(issue_src_idx);
            got_di[got_n]  = int'(issue_dst_idx);
            got_sub[got_n] = int'(issue_sub);
            got_cyc[got_n] = cyc;
            got_n++;
         end
         if (done) begin
            done_cnt++;
            done_cyc = cyc;
         end
      end
   end

   // Expected step list from the requirements.
   task automatic build_expect(input int vl_i, input int vs_i, input int code, input bit sv,
                               input bit dv, input int sb, input int db,
                               input logic [N-1:0] sm, input logic [N-1:0] dm,
                               input logic [2:0] tp);
      int len, s, d;
      bit s_on, d_on, inv;
      len = code + 1;
      s_on = tp[0]; d_on = tp[1]; inv = tp[2];
      s = vs_i; d = vs_i; exp_n = 0;
      while (1) begin
         while (s < vl_i && s_on && ((sm[s] ^ inv) == 1'b0)) s++;
         while (d < vl_i && d_on && ((dm[d] ^ inv) == 1'b0)) d++;
         if (s >= vl_i || d >= vl_i) break;
         for (int k = 0; k < len; k++) begin
            exp_sr[exp_n]  = sv ? (sb + s * len + k) % 128 : (sb + k) % 128;
            exp_dr[exp_n]  = dv ? (db + d * len + k) % 128 : (db + k) % 128;
            exp_si[exp_n]  = s;
            exp_di[exp_n]  = d;
            exp_sub[exp_n] = k;
            exp_n++;
         end
         if ((!sv && s_on) || (!dv && d_on)) break;
         s++; d++;
      end
   endtask

   int start_cyc = 0;

   task automatic launch(input int vl_i, input int vs_i, input int code, input bit sv,
                         input bit dv, input int sb, input int db,
                         input logic [N-1:0] sm, input logic [N-1:0] dm,
                         input logic [2:0] tp);
      @(posedge clk); #1;
      vl = IW'(vl_i); vstart_in = IW'(vs_i); svlen_code = 2'(code);
      src_vec = sv; dst_vec = dv; src_base = RW'(sb); dst_base = RW'(db);
      src_mask = sm; dst_mask = dm; tpred = tp;
      got_n = 0; done_cnt = 0;
      start = 1'b1;
      @(posedge clk); #1;
      start_cyc = cyc;
      start = 1'b0;
   endtask

   task automatic wait_done();
      for (int w = 0; w < 3000 && done_cnt == 0; w++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic run_case(input string tag, input int vl_i, input int vs_i, input int code,
                           input bit sv, input bit dv, input int sb, input int db,
                           input logic [N-1:0] sm, input logic [N-1:0] dm,
                           input logic [2:0] tp);
      build_expect(vl_i, vs_i, code, sv, dv, sb, db, sm, dm, tp);
      launch(vl_i, vs_i, code, sv, dv, sb, db, sm, dm, tp);
      wait_done();
      chk(got_n == exp_n, tag, "accepted step count", got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++) begin
         chk(got_sr[i] == exp_sr[i] && got_dr[i] == exp_dr[i] && got_si[i] == exp_si[i] &&
             got_di[i] == exp_di[i] && got_sub[i] == exp_sub[i],
             tag, $sformatf("step %0d dst_reg (src_reg %0d/%0d, idx %0d,%0d/%0d,%0d, sub %0d/%0d)",
                            i, got_sr[i], exp_sr[i], got_si[i], got_di[i], exp_si[i], exp_di[i],
                            got_sub[i], exp_sub[i]),
             got_dr[i], exp_dr[i]);
      end
      chk(done_cnt == 1, "R10", $sformatf("%s done pulse count", tag), done_cnt, 1);
      chk(vstart_out == '0, "R10", $sformatf("%s vstart after completion", tag), int'(vstart_out), 0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      @(negedge clk);
      chk(issue_valid == 1'b0, "R1", "issue_valid after reset", int'(issue_valid), 0);
      chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
      chk(vstart_out == '0, "R1", "vstart_out after reset", int'(vstart_out), 0);
   endtask

   task automatic t_plain_vector();
      run_case("R2", 5, 0, 0, 1'b1, 1'b1, 10, 40, '0, '0, 3'b000);
      for (int i = 1; i < got_n; i++)
         chk(got_cyc[i] == got_cyc[i-1] + 1, "R12", "back-to-back acceptance cycle",
             got_cyc[i], got_cyc[i-1] + 1);
   endtask

   task automatic t_scalar_and_groups();
      run_case("R3", 4, 0, 2, 1'b0, 1'b1, 20, 30, '0, '0, 3'b000);
      run_case("R4", 3, 0, 3, 1'b1, 1'b1, 0, 100, '0, '0, 3'b000);
      run_case("R4", 3, 0, 1, 1'b1, 1'b1, 4, 60, 64'b101, '0, 3'b001);
   endtask

   task automatic t_vstart();
      run_case("R5", 6, 3, 0, 1'b1, 1'b1, 0, 8, '0, '0, 3'b000);
      run_case("R5", 6, 7, 0, 1'b1, 1'b1, 0, 8, '0, '0, 3'b000);
   endtask

   task automatic t_twin_pred();
      run_case("R6", 8, 0, 0, 1'b1, 1'b1, 0, 64, 64'b1011_0110, 64'b0101_1101, 3'b011);
      run_case("R6", 8, 0, 0, 1'b1, 1'b1, 0, 64, 64'b0000_0001, 64'b1100_1010, 3'b010);
   endtask

   task automatic t_inverted();
      run_case("R7", 8, 0, 0, 1'b1, 1'b1, 0, 64, 64'b1011_0110, 64'b0101_1101, 3'b111);
      run_case("R7", 6, 0, 0, 1'b1, 1'b1, 2, 50, '0, '0, 3'b100);
   endtask

   task automatic t_scalar_pred();
      run_case("R8", 8, 0, 0, 1'b1, 1'b0, 16, 3, '0, 64'b0010_0000, 3'b010);
      run_case("R8", 8, 0, 1, 1'b0, 1'b1, 9, 70, 64'b0000_0011, '0, 3'b101);
   endtask

   task automatic t_zero_vl();
      launch(0, 0, 0, 1'b1, 1'b1, 0, 0, '0, '0, 3'b000);
      wait_done();
      chk(got_n == 0, "R9", "steps issued with vl=0", got_n, 0);
      chk(done_cnt == 1, "R9", "done pulses with vl=0", done_cnt, 1);
      chk(done_cyc == start_cyc, "R9", "done cycle relative to start edge", done_cyc, start_cyc);
   endtask

   task automatic t_trap();
      launch(8, 0, 0, 1'b1, 1'b1, 0, 32, '0, '0, 3'b000);
      for (int w = 0; w < 100; w++) begin
         @(negedge clk);
         if (issue_valid && issue_dst_idx == IW'(3)) break;
      end
      @(posedge clk); #1 trap = 1'b1;
      @(posedge clk); #1 trap = 1'b0;
      wait_done();
      chk(got_n == 4, "R11", "steps accepted before trap", got_n, 4);
      chk(done_cnt == 1, "R11", "done pulses after trap", done_cnt, 1);
      chk(vstart_out == IW'(4), "R11", "vstart_out after trap", int'(vstart_out), 4);
      chk(issue_valid == 1'b0, "R11", "issue_valid after trap", int'(issue_valid), 0);
   endtask

   task automatic t_backpressure();
      bp_mode = 1'b1;
      run_case("R12", 5, 0, 1, 1'b1, 0, 3, 90, '0, '0, 3'b000);
      bp_mode = 1'b0;
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; trap = 1'b0;
      vl = '0; vstart_in = '0; svlen_code = '0; src_vec = 1'b0; dst_vec = 1'b0;
      src_base = '0; dst_base = '0; src_mask = '0; dst_mask = '0; tpred = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_plain_vector();
      t_scalar_and_groups();
      t_vstart();
      t_twin_pred();
      t_inverted();
      t_scalar_pred();
      t_zero_vl();
      t_trap();
      run_case("R10", 3, 0, 0, 1'b1, 1'b1, 1, 2, '0, '0, 3'b000);
      t_backpressure();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule